// File: doc/BRIEF.md
# Battery-Backed Byte-Wide SRAM Port

This block is a clocked model of an asynchronous byte-wide static memory port with power-fail protection. A host drives active-low select, output-enable and write-enable strobes, an address and a write byte. The block decodes the bus mode each clock, keeps the bytes in an internal array and controls a separate output-enable for the data-bus drivers. All strobes are sampled on the rising clock edge. Every output is registered, so it reflects the inputs seen at the previous edge.

Two digital flags from external comparators report the supply state. One flag says the supply is below the write-protect point. The other says it is below the battery level. While the write-protect flag is set, the bus is locked: no byte is read or written, and the drivers stay off. The power-source indication selects the battery only when the supply is below both points, which means below the lower of the two thresholds.

Timing rules become clock counts. Once a write ends, both strobes must rest for a set number of clocks. A cycle that starts too early is refused and flagged. A write whose address moves while the cycle is open is also refused and flagged.

Top module: `bbsram_port`

## Requirements
- R1: While ce_n is high the block is deselected: dq_oe is 0 one clock later, and strobes and data applied then leave the stored bytes unchanged.
- R2: ce_n low with we_n low is a write, whatever the level of oe_n. The byte is stored at the address that was present when the cycle started.
- R3: ce_n low, we_n high and oe_n low is a driven read. One clock later dq_oe is 1 and dq_out holds the byte stored at addr. While the strobes stay put, dq_out follows each address change with the same one-clock latency.
- R4: ce_n low, we_n high and oe_n high is a read with the bus left undriven: dq_oe is 0 one clock later.
- R5: A write opens at the later of the ce_n and we_n falling edges and closes at the first of them to rise. The byte committed is dq_in as sampled at the last clock on which both strobes were still low.
- R6: If oe_n is low when a write opens, read data of the addressed byte (its old value) is driven for exactly OFF_DLY clocks (default 3). After that dq_oe returns to 0 while the write continues.
- R7: While pf_flag is 1, reads and writes are blocked and dq_oe is 0 one clock later. Stored bytes keep their values and can be read after pf_flag clears.
- R8: If pf_flag rises while a write is open, that write is aborted and its byte is not committed.
- R9: on_battery is 1 one clock after pf_flag and lo_flag are both 1. It is 0 one clock after either flag is 0.
- R10: After a write closes, a new cycle (a ce_n fall or the opening of a write) seen within the next RECOV clocks (default 4) is refused. err_pulse is 1 for one clock, and the refused cycle neither drives the bus nor writes until ce_n returns high.
- R11: A change of addr while a write is open raises addr_viol for one clock, and that write is not committed.
- R12: During and right after reset, dq_oe, err_pulse, addr_viol and on_battery are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data bus, incoming side |
| dq_out | output | DATA_W | Data bus, outgoing side |
| dq_oe | output | 1 | Data bus driver enable |
| pf_flag | input | 1 | Supply below write-protect point |
| lo_flag | input | 1 | Supply below battery level |
| on_battery | output | 1 | Device powered from battery |
| err_pulse | output | 1 | One-clock pulse: cycle refused for recovery time |
| addr_viol | output | 1 | One-clock pulse: address moved during a write |

## Verification
Most internal faults here only show up later, as a wrong byte on a following driven read. A write that was committed when it should have been dropped, dropped when it should have been committed, or put at the wrong address shows up on the next read of that location, a few clocks later. Faults in the drive path show up at once, as dq_oe at the wrong level one clock after the strobes. A recovery or off-delay counter of the wrong length moves err_pulse, or the clock on which dq_oe falls, by one or more clocks. Each scenario therefore ends with a read-back of the bytes it could have touched.

// File: rtl/bbsram_pkg.sv
package bbsram_pkg;

    // Bus mode decoded from the strobes and the lockout flag
    typedef enum logic [2:0] {
        MD_DESEL  = 3'd0,
        MD_WRITE  = 3'd1,
        MD_RD_DRV = 3'd2,
        MD_RD_HIZ = 3'd3,
        MD_LOCK   = 3'd4
    } bb_mode_e;

endpackage

// File: rtl/bbsram_mode_dec.sv
module bbsram_mode_dec
    import bbsram_pkg::*;
(
    input  logic     ce_n,
    input  logic     oe_n,
    input  logic     we_n,
    input  logic     lock,
    output bb_mode_e mode
);

    // Lockout wins over everything; then select, then write over read
    always_comb begin
        if (lock)
            mode = MD_LOCK;
        else if (ce_n)
            mode = MD_DESEL;
        else if (!we_n)
            mode = MD_WRITE;
        else if (!oe_n)
            mode = MD_RD_DRV;
        else
            mode = MD_RD_HIZ;
    end

endmodule

// File: rtl/bbsram_array.sv
module bbsram_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Storage is not reset: it models retained contents
    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/bbsram_pwr_sel.sv
module bbsram_pwr_sel (
    input  logic below_pf,
    input  logic below_lo,
    output logic use_batt
);

    // Switch point is the lower threshold: supply must be under both
    assign use_batt = below_pf & below_lo;

endmodule

// File: rtl/bbsram_port.sv
module bbsram_port
    import bbsram_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int OFF_DLY = 3,
    parameter int RECOV   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic              pf_flag,
    input  logic              lo_flag,
    output logic              on_battery,
    output logic              err_pulse,
    output logic              addr_viol
);

    localparam int OFF_W = (OFF_DLY < 1) ? 1 : $clog2(OFF_DLY + 1);
    localparam int REC_W = (RECOV < 1) ? 1 : $clog2(RECOV + 1);

    typedef struct packed {
        logic              prev_sel;
        logic              prev_w;
        logic              ign;
        logic              wr_on;
        logic              wr_bad;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
        logic [OFF_W-1:0]  off_cnt;
        logic [REC_W-1:0]  rec_cnt;
        logic              dq_oe;
        logic [DATA_W-1:0] dq_out;
        logic              batt;
        logic              err;
        logic              aviol;
    } port_st_t;

    port_st_t st_d, st_q;

    bb_mode_e          mode;
    logic              batt_req;
    logic [DATA_W-1:0] rd_data;
    logic              mem_we;

    bbsram_mode_dec u_dec (
        .ce_n (ce_n),
        .oe_n (oe_n),
        .we_n (we_n),
        .lock (pf_flag),
        .mode (mode)
    );

    bbsram_pwr_sel u_pwr (
        .below_pf (pf_flag),
        .below_lo (lo_flag),
        .use_batt (batt_req)
    );

    bbsram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (st_q.wr_addr),
        .wr_data (st_q.wr_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    logic sel, wcond, sel_rise, w_rise, rec_busy, accept, rd_drv, wr_drv;

    always_comb begin
        st_d        = st_q;
        st_d.err    = 1'b0;
        st_d.aviol  = 1'b0;
        mem_we      = 1'b0;

        sel      = ~ce_n;
        wcond    = ~ce_n & ~we_n;
        sel_rise = sel & ~st_q.prev_sel;
        w_rise   = wcond & ~st_q.prev_w;
        rec_busy = (st_q.rec_cnt != '0);

        st_d.prev_sel = sel;
        st_d.prev_w   = wcond;
        st_d.batt     = batt_req;

        if (rec_busy)
            st_d.rec_cnt = st_q.rec_cnt - 1'b1;

        // Early cycle start: refuse it until the select is released
        if (!sel)
            st_d.ign = 1'b0;
        else if ((sel_rise | w_rise) && rec_busy && !pf_flag) begin
            st_d.ign = 1'b1;
            st_d.err = 1'b1;
        end

        accept = ~st_d.ign & ~pf_flag;

        if (st_q.wr_on) begin
            if (st_q.off_cnt != '0)
                st_d.off_cnt = st_q.off_cnt - 1'b1;
            if (pf_flag) begin
                // lockout mid-write: drop the byte
                st_d.wr_on   = 1'b0;
                st_d.off_cnt = '0;
            end else if (!wcond) begin
                // first strobe released: commit unless flagged
                st_d.wr_on   = 1'b0;
                st_d.off_cnt = '0;
                mem_we       = ~st_q.wr_bad;
                st_d.rec_cnt = REC_W'(RECOV);
            end else begin
                st_d.wr_data = dq_in;
                if ((addr != st_q.wr_addr) && !st_q.wr_bad) begin
                    st_d.wr_bad = 1'b1;
                    st_d.aviol  = 1'b1;
                end
            end
        end else if (w_rise && accept) begin
            st_d.wr_on   = 1'b1;
            st_d.wr_bad  = 1'b0;
            st_d.wr_addr = addr;
            st_d.wr_data = dq_in;
            st_d.off_cnt = oe_n ? '0 : OFF_W'(OFF_DLY);
        end

        rd_drv = (mode == MD_RD_DRV) && !st_d.ign;
        wr_drv = st_d.wr_on && (st_d.off_cnt != '0) && !oe_n && !pf_flag;

        st_d.dq_oe  = rd_drv | wr_drv;
        st_d.dq_out = (rd_drv | wr_drv) ? rd_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign dq_out     = st_q.dq_out;
    assign dq_oe      = st_q.dq_oe;
    assign on_battery = st_q.batt;
    assign err_pulse  = st_q.err;
    assign addr_viol  = st_q.aviol;

endmodule

// File: rtl/bbsram_port_chk.sv
module bbsram_port_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic pf_flag,
    input logic lo_flag,
    input logic dq_oe,
    input logic on_battery,
    input logic err_pulse,
    input logic addr_viol
);

    // R1
    desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dq_oe);

    // R4
    oe_high_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n) |=> !dq_oe);

    // R7
    lock_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_flag |=> !dq_oe);

    // R9
    batt_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_flag && lo_flag) |=> on_battery);

    // R9
    batt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pf_flag && lo_flag) |=> !on_battery);

    // R10
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R11
    viol_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_viol |=> !addr_viol);

    // R6
    wr_hiz_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n && oe_n) |=> !dq_oe);

endmodule

bind bbsram_port bbsram_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .pf_flag    (pf_flag),
    .lo_flag    (lo_flag),
    .dq_oe      (dq_oe),
    .on_battery (on_battery),
    .err_pulse  (err_pulse),
    .addr_viol  (addr_viol)
);

// File: tb/bbsram_port_test.sv
module bbsram_port_test;

    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int OFF = 3;
    localparam int REC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, pf_flag = 1'b0, lo_flag = 1'b0;
    logic          on_battery, err_pulse, addr_viol;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bbsram_port #(.ADDR_W(AW), .DATA_W(DW), .OFF_DLY(OFF), .RECOV(REC)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .pf_flag(pf_flag), .lo_flag(lo_flag), .on_battery(on_battery),
        .err_pulse(err_pulse), .addr_viol(addr_viol)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic release_bus();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    // plain write, strobes released together, then recovery idle
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe_lvl = 1'b1);
        addr = a; dq_in = d; oe_n = oe_lvl; ce_n = 1'b0; we_n = 1'b0;
        step(2);
        release_bus();
        step(REC + 2);
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        addr = a; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        step();
        check({req, " read oe"}, dq_oe, 1);
        check({req, " read data"}, dq_out, exp);
        release_bus();
        step();
        check("R1 idle after read", dq_oe, 0);
    endtask

    task automatic t_reset();
        check("R12 dq_oe", dq_oe, 0);
        check("R12 err_pulse", err_pulse, 0);
        check("R12 addr_viol", addr_viol, 0);
        check("R12 on_battery", on_battery, 0);
    endtask

    task automatic t_write_read();
        do_write(8'h10, 8'hA5);
        do_write(8'h11, 8'h5A);
        do_write(8'hFF, 8'h00);
        do_write(8'h00, 8'hFF, 1'b0);   // oe low during write
        read_chk(8'h10, 8'hA5, "R2");
        read_chk(8'h11, 8'h5A, "R2");
        read_chk(8'hFF, 8'h00, "R2");
        read_chk(8'h00, 8'hFF, "R2 oe low");
        // R3: address ripple with strobes held
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        addr = 8'h10; step(); check("R3 ripple a", dq_out, 8'hA5);
        addr = 8'h11; step(); check("R3 ripple b", dq_out, 8'h5A);
        addr = 8'h00; step(); check("R3 ripple c", dq_out, 8'hFF);
        check("R3 oe held", dq_oe, 1);
        release_bus(); step();
    endtask

    task automatic t_oe_high();
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = 8'h10;
        step(); check("R4 undriven", dq_oe, 0);
        release_bus(); step();
    endtask

    task automatic t_deselect();
        ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b0; addr = 8'h10; dq_in = 8'h33;
        step(); check("R1 deselect hiz", dq_oe, 0);
        step(2);
        release_bus(); step(REC + 2);
        read_chk(8'h10, 8'hA5, "R1 deselect ignored");
    endtask

    task automatic t_framing();
        // we falls first, ce opens the write; data changes inside the cycle
        addr = 8'h20; dq_in = 8'h11; we_n = 1'b0; step();
        ce_n = 1'b0; step();
        dq_in = 8'h22; step();
        dq_in = 8'h77; step();
        ce_n = 1'b1; dq_in = 8'h99; step();
        we_n = 1'b1; step(REC + 2);
        read_chk(8'h20, 8'h77, "R5 last data");
    endtask

    task automatic t_oe_first();
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 8'h20; dq_in = 8'hC3;
        step(); check("R6 pre-read", dq_oe, 1);
        we_n = 1'b0;
        for (int i = 0; i < OFF; i++) begin
            step(); check("R6 drive window", dq_oe, 1);
            check("R6 old data", dq_out, 8'h77);
        end
        step(); check("R6 drivers off", dq_oe, 0);
        release_bus(); step(REC + 2);
        read_chk(8'h20, 8'hC3, "R6 committed");
    endtask

    task automatic t_lockout();
        pf_flag = 1'b1; step();
        do_write(8'h10, 8'hEE);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 8'h10;
        step(); check("R7 read blocked", dq_oe, 0);
        release_bus(); pf_flag = 1'b0; step(2);
        read_chk(8'h10, 8'hA5, "R7 contents kept");
    endtask

    task automatic t_abort();
        addr = 8'h11; dq_in = 8'h44; ce_n = 1'b0; we_n = 1'b0;
        step();
        pf_flag = 1'b1; step();
        release_bus(); step();
        pf_flag = 1'b0; step(REC + 2);
        read_chk(8'h11, 8'h5A, "R8 aborted");
    endtask

    task automatic t_battery();
        pf_flag = 1'b1; lo_flag = 1'b0; step(); check("R9 pf only", on_battery, 0);
        pf_flag = 1'b0; lo_flag = 1'b1; step(); check("R9 lo only", on_battery, 0);
        pf_flag = 1'b1; step(); check("R9 both", on_battery, 1);
        pf_flag = 1'b0; step(); check("R9 restore", on_battery, 0);
        lo_flag = 1'b0; step();
    endtask

    task automatic t_recovery();
        addr = 8'h30; dq_in = 8'h12; ce_n = 1'b0; we_n = 1'b0;
        step(2);
        release_bus(); step();            // close edge
        addr = 8'h30; dq_in = 8'h34; ce_n = 1'b0; we_n = 1'b0;
        step(); check("R10 err pulse", err_pulse, 1);
        step(); check("R10 err ends", err_pulse, 0);
        release_bus(); step(REC + 2);
        read_chk(8'h30, 8'h12, "R10 refused write");
    endtask

    task automatic t_addr_move();
        addr = 8'h40; dq_in = 8'h56; ce_n = 1'b0; we_n = 1'b0;
        step();
        addr = 8'h41; step(); check("R11 viol pulse", addr_viol, 1);
        step(); check("R11 viol ends", addr_viol, 0);
        release_bus(); step(REC + 2);
        do_write(8'h41, 8'h01);
        do_write(8'h40, 8'h02);
        addr = 8'h40; dq_in = 8'h66; ce_n = 1'b0; we_n = 1'b0;
        step(); addr = 8'h41; step();
        release_bus(); step(REC + 2);
        read_chk(8'h40, 8'h02, "R11 not committed a");
        read_chk(8'h41, 8'h01, "R11 not committed b");
    endtask

    initial begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_write_read();
        t_oe_high();
        t_deselect();
        t_framing();
        t_oe_first();
        t_lockout();
        t_abort();
        t_battery();
        t_recovery();
        t_addr_move();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule